// File: doc/BRIEF.md
# Exception pending control register

This block holds the pending state of three system exceptions: a non-maskable interrupt (NMI), a deferred service-call exception (SVC) and a periodic timer exception (TICK). Software changes that state through a 32-bit memory-mapped word. The bus supplies an address-decoded write strobe and full-word write data. The current state is always visible on the read data. For each exception there is a set bit and, where provided, a clear bit. A 1 in a bit acts on the flag, and a 0 does nothing.

The hardware side has a pend request input for the NMI and for the timer tick. It also has one handler-entry acknowledge pulse per exception. The three pending flags are sent to an exception controller, which arbitrates between them and takes care of vectors. The vector-number fields of the word are not implemented and read as zero.

Top module: `excpend_reg`

## Requirements
- R1: After a clock edge with `rst_n` low, all three pending flags are 0 and `bus_rdata` reads 0.
- R2: A write with bit 31 = 1 makes the NMI pending. Bit 31 of `bus_rdata` shows the NMI pending state.
- R3: `nmi_ack` clears the NMI pending flag. If `nmi_req` is high in the same cycle, the flag stays 1, so a re-raise during the handler reads back as 1.
- R4: A write with bit 28 = 1 makes the SVC pending, and bit 28 of `bus_rdata` shows that state. No hardware input can set it. `svc_ack` clears it.
- R5: A write with bit 27 = 1 clears the SVC pending flag. Bit 27 always reads 0.
- R6: A write with bit 26 = 1, or a high `tick_req`, makes the timer pending. Bit 26 of `bus_rdata` shows that state.
- R7: A write with bit 25 = 1, or `tick_ack`, clears the timer pending flag. Bit 25 always reads 0.
- R8: When one write sets both the set bit and the clear bit of the same exception, the flag ends up 0.
- R9: Any set in a cycle overrides any clear in that cycle. A hardware request overrides write-clear and acknowledge, and a software write-set overrides acknowledge. The exception is the R8 case, where write-set and write-clear meet.
- R10: Writing 0 to a bit has no effect. With `bus_wr_en` low, write data has no effect.
- R11: All bits of `bus_rdata` other than 31, 28 and 26 read 0.
- R12: `nmi_pend`, `svc_pend` and `tick_pend` always equal bits 31, 28 and 26 of `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Address-decoded write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (current flag state) |
| nmi_req | input | 1 | Hardware NMI pend request |
| nmi_ack | input | 1 | NMI handler-entry pulse |
| svc_ack | input | 1 | SVC handler-entry pulse |
| tick_req | input | 1 | Timer tick pend pulse |
| tick_ack | input | 1 | Timer handler-entry pulse |
| nmi_pend | output | 1 | NMI pending flag |
| svc_pend | output | 1 | SVC pending flag |
| tick_pend | output | 1 | Timer pending flag |

## Verification
A set and a clear can reach the same flag in one cycle. There are three ways this happens: a hardware request against an acknowledge or a write-clear, a write-set against an acknowledge, and a write-set against a write-clear in the same data word. Directed steps produce each of these collisions on purpose. A long random phase raises requests, acknowledges and write bits at the same time, over and over. Each outcome is judged against a behavioural model in the bench. The model applies the priority as an ordered if-chain, and the comparison runs on every clock.

// File: rtl/excpend_pkg.sv
package excpend_pkg;
    localparam int NUM_EXC  = 3;
    localparam int WORD_W   = 32;
    localparam int EXC_NMI  = 0;
    localparam int EXC_SVC  = 1;
    localparam int EXC_TICK = 2;

    typedef struct packed {
        logic [NUM_EXC-1:0] set_wr;
        logic [NUM_EXC-1:0] clr_wr;
    } wr_fields_t;

    function automatic int set_pos(int idx);
        case (idx)
            EXC_NMI: return 31;
            EXC_SVC: return 28;
            default: return 26;
        endcase
    endfunction

    function automatic int clr_pos(int idx);
        case (idx)
            EXC_SVC:  return 27;
            EXC_TICK: return 25;
            default:  return 0;
        endcase
    endfunction

    function automatic bit has_clr(int idx);
        return idx != EXC_NMI;
    endfunction

    function automatic bit has_hw_set(int idx);
        return idx != EXC_SVC;
    endfunction
endpackage

// File: rtl/excpend_decode.sv
module excpend_decode
    import excpend_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output wr_fields_t        fields
);
    always_comb begin
        fields = '0;
        for (int i = 0; i < NUM_EXC; i++) begin
            fields.set_wr[i] = wr_en && wdata[set_pos(i)];
            fields.clr_wr[i] = has_clr(i) && wr_en && wdata[clr_pos(i)];
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{wdata[30:29], wdata[24:0]};
endmodule

// File: rtl/excpend_flag.sv
module excpend_flag #(
    parameter bit HAS_HW_SET = 1'b1,
    parameter bit HAS_WR_CLR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_set,
    input  logic wr_clr,
    input  logic hw_set,
    input  logic ack,
    output logic pend
);
    typedef struct packed {
        logic pend;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic hw_eff, clr_eff, sw_eff;

    always_comb begin
        hw_eff  = HAS_HW_SET ? hw_set : 1'b0;
        clr_eff = (HAS_WR_CLR ? wr_clr : 1'b0);
        sw_eff  = wr_set && !clr_eff;
        st_d    = st_q;
        if (hw_eff || sw_eff)
            st_d.pend = 1'b1;
        else if (clr_eff || ack)
            st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    // R9: a hardware request is never lost to a simultaneous clear
    p_hw_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_eff |=> pend);
    // R8: write-clear beats write-set in the same word
    p_wrclr_beats_wrset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_eff && !hw_eff) |=> !pend);
    // R7 / R3: handler entry clears when nothing sets
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hw_eff && !wr_set) |=> !pend);
    // R10: no stimulus, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr && !hw_eff && !ack) |=> $stable(pend));
endmodule

// File: rtl/excpend_readback.sv
module excpend_readback
    import excpend_pkg::*;
(
    input  logic [NUM_EXC-1:0] pend,
    output logic [WORD_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_EXC; i++)
            rdata[set_pos(i)] = pend[i];
    end
endmodule

// File: rtl/excpend_reg.sv
module excpend_reg
    import excpend_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_en,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        nmi_req,
    input  logic        nmi_ack,
    input  logic        svc_ack,
    input  logic        tick_req,
    input  logic        tick_ack,
    output logic        nmi_pend,
    output logic        svc_pend,
    output logic        tick_pend
);
    wr_fields_t         fields;
    logic [NUM_EXC-1:0] hw_vec, ack_vec, pend_vec;

    assign hw_vec  = {tick_req, 1'b0, nmi_req};
    assign ack_vec = {tick_ack, svc_ack, nmi_ack};

    excpend_decode u_dec (
        .wr_en  (bus_wr_en),
        .wdata  (bus_wdata),
        .fields (fields)
    );

    for (genvar i = 0; i < NUM_EXC; i++) begin : g_flag
        localparam bit HW = has_hw_set(i);
        localparam bit CL = has_clr(i);
        excpend_flag #(.HAS_HW_SET(HW), .HAS_WR_CLR(CL)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_set (fields.set_wr[i]),
            .wr_clr (fields.clr_wr[i]),
            .hw_set (hw_vec[i]),
            .ack    (ack_vec[i]),
            .pend   (pend_vec[i])
        );
    end

    excpend_readback u_rb (
        .pend  (pend_vec),
        .rdata (bus_rdata)
    );

    assign nmi_pend  = pend_vec[EXC_NMI];
    assign svc_pend  = pend_vec[EXC_SVC];
    assign tick_pend = pend_vec[EXC_TICK];

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~32'h9400_0000) == 32'h0);
    p_flags_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
        {nmi_pend, svc_pend, tick_pend} == {bus_rdata[31], bus_rdata[28], bus_rdata[26]});
    p_svc_write_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_pend) |-> $past(bus_wr_en && bus_wdata[28]));
    p_nmi_reraise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> nmi_pend);
endmodule

// File: tb/excpend_reg_test.sv
`timescale 1ns/1ps
module excpend_reg_test;
    logic clk = 0, rst_n = 0;
    logic bus_wr_en = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic nmi_req = 0, nmi_ack = 0, svc_ack = 0, tick_req = 0, tick_ack = 0;
    logic nmi_pend, svc_pend, tick_pend;
    int checks = 0, fails = 0;
    bit m_nmi, m_svc, m_tick, model_on = 0;

    always #4 clk = ~clk;

    excpend_reg uut (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_nmi <= 0; m_svc <= 0; m_tick <= 0;
        end else begin
            if (nmi_req || (bus_wr_en && bus_wdata[31])) m_nmi <= 1;
            else if (nmi_ack) m_nmi <= 0;
            if (bus_wr_en && bus_wdata[27]) m_svc <= 0;
            else if (bus_wr_en && bus_wdata[28]) m_svc <= 1;
            else if (svc_ack) m_svc <= 0;
            if (tick_req) m_tick <= 1;
            else if (bus_wr_en && bus_wdata[25]) m_tick <= 0;
            else if (bus_wr_en && bus_wdata[26]) m_tick <= 1;
            else if (tick_ack) m_tick <= 0;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) if (model_on) begin
        check(bus_rdata, {m_nmi, 2'b0, m_svc, 1'b0, m_tick, 26'b0}, "R11 model");
        check({29'b0, nmi_pend, svc_pend, tick_pend}, {29'b0, m_nmi, m_svc, m_tick}, "R12 model");
    end

    task automatic step(input logic we, input logic [31:0] wd,
                        input logic nr, input logic na, input logic sa,
                        input logic tr, input logic ta);
        @(negedge clk);
        bus_wr_en = we; bus_wdata = wd;
        nmi_req = nr; nmi_ack = na; svc_ack = sa; tick_req = tr; tick_ack = ta;
        @(posedge clk); #1;
        bus_wr_en = 0; nmi_req = 0; nmi_ack = 0; svc_ack = 0; tick_req = 0; tick_ack = 0;
    endtask

    initial begin
        #(8 * 5000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check(bus_rdata, 32'h0, "R1 reset");
        check({29'b0, nmi_pend, svc_pend, tick_pend}, 32'h0, "R1 flags");
        @(negedge clk); rst_n = 1; model_on = 1;
        step(1, 32'h9400_0000, 0,0,0,0,0); check(bus_rdata, 32'h9400_0000, "R2 R4 R6 set");
        step(1, 32'h0, 0,0,0,0,0);          check(bus_rdata, 32'h9400_0000, "R10 write zero");
        step(0, 32'hFFFF_FFFF, 0,0,0,0,0);  check(bus_rdata, 32'h9400_0000, "R10 no strobe");
        step(1, 32'h0800_0000, 0,0,0,0,0);  check(bus_rdata, 32'h8400_0000, "R5 svc clear");
        step(0, 0, 0,1,0,0,0);              check(bus_rdata, 32'h0400_0000, "R3 nmi ack");
        step(0, 0, 1,1,0,0,0);              check(bus_rdata, 32'h8400_0000, "R3 reraise");
        step(0, 0, 0,0,0,0,1);              check(bus_rdata, 32'h8000_0000, "R7 tick ack");
        step(0, 0, 0,1,0,0,0);              check(bus_rdata, 32'h0, "R3 ack");
        step(0, 0, 0,0,0,1,0);              check(bus_rdata, 32'h0400_0000, "R6 tick req");
        step(1, 32'h0200_0000, 0,0,0,1,1);  check(bus_rdata, 32'h0400_0000, "R9 hw beats clear");
        step(1, 32'h0200_0000, 0,0,0,0,0);  check(bus_rdata, 32'h0, "R7 write clear");
        step(1, 32'h1800_0000, 0,0,0,0,0);  check(bus_rdata, 32'h0, "R8 svc both");
        step(1, 32'h0600_0000, 0,0,0,0,0);  check(bus_rdata, 32'h0, "R8 tick both");
        step(1, 32'h1000_0000, 0,0,1,0,0);  check(bus_rdata, 32'h1000_0000, "R9 wset beats ack");
        step(0, 0, 0,0,1,0,0);              check(bus_rdata, 32'h0, "R4 svc ack");
        step(1, 32'hFFFF_FFFF, 0,0,0,0,0);  check(bus_rdata, 32'h8000_0000, "R11 R8 all ones");
        check({29'b0, nmi_pend, svc_pend, tick_pend}, 32'h4, "R12 pins");
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r = $urandom;
            step(r[0], {$urandom} & 32'h9E00_0000, r[1]&r[2], r[3], r[4], r[5]&r[6], r[7]);
        end
        model_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule